// File: doc/BRIEF.md
# Byte-Lane Memory Port Controller with Flow-Through or Pipelined Read

This block is the control and data path of one synchronous memory port. The port carries an 18-bit word split into two 9-bit lanes. Every control input is captured on the rising clock edge: two chip enables of opposite polarity, a read/write select, one active-low select per lane, the address and the write word. From the captured controls the block raises one write strobe per lane into a small behavioural array. It returns the read word together with one drive-enable flag per lane. Those flags stand for the port's tri-state drivers.

A static mode input chooses how reads come out. In flow-through mode the array word appears in the cycle right after the access is sampled. In pipelined mode one extra register holds it back by a further cycle. Chip-enable deselection follows that extra stage in pipelined mode. The lane selects always act one stage after sampling. An output-enable input gates the drive flags without a clock and leaves the captured access untouched.

Top module: `bytelane_port`

## Requirements
- R1: The port counts as selected for a cycle only if `ce_lo_n` is 0 and `ce_hi` is 1 at the sampling edge. With any other pair, that cycle raises no write strobe and changes no array lane.
- R2: A selected write with `rd_wr`=0 raises `wr_stb[l]` in the cycle after the sampling edge for each lane whose `bsel_n[l]` was 0. Lane 1 is the upper lane, bits 17..9, and lane 0 is the lower lane, bits 8..0. The array lane takes the new data at the next edge. Lanes whose select was 1 keep their contents.
- R3: In flow-through mode (`pipe_mode`=0), a selected read with `rd_wr`=1 makes `rdata` equal the addressed word in the cycle after the sampling edge. In that cycle `drv_en[l]` is 1 for each lane whose select was 0.
- R4: In pipelined mode (`pipe_mode`=1), the read word and its drive flags appear one cycle later than in flow-through mode.
- R5: In flow-through mode the drive flags follow the chip-enable state of the most recent edge. In pipelined mode they follow the chip-enable state of the edge before that, so deselecting or re-activating the outputs takes two cycles.
- R6: In both modes, the lane selects that gate `drv_en` are the ones captured at the most recent edge.
- R7: `oe_n`=1 forces `drv_en` to 0 in the same cycle, with no clock involved. It changes neither the captured access nor the read word delivered later.
- R8: In pipelined mode, `rdata` keeps the last captured read word through deselected, idle and write cycles. A write issued right after a read to the same address does not change the word delivered for that read.
- R9: Reset clears every array word, holds `drv_en` and `wr_stb` at 0, and leaves the pipeline register at 0.
- R10: A read issued in the cycle right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | Static: 0 flow-through, 1 pipelined read |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| rd_wr | input | 1 | 1 read, 0 write |
| bsel_n | input | N_LANES (2) | Active-low lane selects, bit 1 upper, bit 0 lower |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | N_LANES*LANE_W (18) | Write word |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wr_stb | output | N_LANES (2) | Per-lane write strobes into the array |
| rdata | output | N_LANES*LANE_W (18) | Read word |
| drv_en | output | N_LANES (2) | Per-lane output drive enables |

## Verification
The bench builds the block with its defaults: two lanes of 9 bits and a 4-bit address, so 16 words. Every array word can be reached, and a reset that clears them all can be checked cheaply. The bench runs the same address and data patterns once per output mode, with a reset in between. That covers the one-cycle versus two-cycle deselect, the single-stage lane selects that end up gating the previous read in pipelined mode, and the pipeline register holding across writes. Partial-lane writes followed by full-word reads show which lanes were kept.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } outmode_e;

  // Port is live only with the low enable asserted and the high enable asserted.
  function automatic logic port_enabled(input logic en_lo_n, input logic en_hi);
    return (!en_lo_n) && en_hi;
  endfunction

  // One lane is written when a selected write targets it.
  function automatic logic lane_write(input logic sel, input logic rd, input logic bs_n);
    return sel && !rd && !bs_n;
  endfunction

  // One lane drives when a live read targets it and the output enable is low.
  function automatic logic lane_drive(input logic live, input logic bs_n, input logic oe_low_n);
    return live && !bs_n && !oe_low_n;
  endfunction

endpackage

// File: rtl/bytelane_inreg.sv
module bytelane_inreg
  import bytelane_pkg::*;
#(
  parameter int N_LANES = 2,
  parameter int LANE_W  = 9,
  parameter int ADDR_W  = 4,
  localparam int DW     = N_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_lo_n,
  input  logic               ce_hi,
  input  logic               rd_wr,
  input  logic [N_LANES-1:0] bsel_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  output logic               s1_sel,
  output logic               s1_rd,
  output logic [N_LANES-1:0] s1_bsel_n,
  output logic [ADDR_W-1:0]  s1_addr,
  output logic [DW-1:0]      s1_wdata,
  output logic               s2_sel,
  output logic               s2_rd
);

  // First stage: every control, address and data input.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_sel    <= 1'b0;
      s1_rd     <= 1'b0;
      s1_bsel_n <= '1;
      s1_addr   <= '0;
      s1_wdata  <= '0;
    end else begin
      s1_sel    <= port_enabled(ce_lo_n, ce_hi);
      s1_rd     <= rd_wr;
      s1_bsel_n <= bsel_n;
      s1_addr   <= addr;
      s1_wdata  <= wdata;
    end
  end

  // Second stage: only the chip-enable state and direction are carried on.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_sel <= 1'b0;
      s2_rd  <= 1'b0;
    end else begin
      s2_sel <= s1_sel;
      s2_rd  <= s1_rd;
    end
  end

endmodule

// File: rtl/bytelane_array.sv
module bytelane_array #(
  parameter int N_LANES = 2,
  parameter int LANE_W  = 9,
  parameter int ADDR_W  = 4,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DW     = N_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]      wr_word,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DW-1:0]      rd_word
);

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_stb[l]) begin
        cells[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
      end
    end

    assign rd_word[l*LANE_W +: LANE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/bytelane_outpath.sv
module bytelane_outpath
  import bytelane_pkg::*;
#(
  parameter int N_LANES = 2,
  parameter int LANE_W  = 9,
  localparam int DW     = N_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pipe_mode,
  input  logic               oe_n,
  input  logic               s1_sel,
  input  logic               s1_rd,
  input  logic               s2_sel,
  input  logic               s2_rd,
  input  logic [N_LANES-1:0] s1_bsel_n,
  input  logic [DW-1:0]      arr_word,
  output logic [DW-1:0]      rdata,
  output logic [N_LANES-1:0] drv_en,
  output logic               cap_en
);

  outmode_e          mode;
  logic [DW-1:0]     pipe_q;
  logic              live;

  assign mode   = outmode_e'(pipe_mode);
  assign cap_en = s1_sel && s1_rd;

  // The pipeline register only loads on a selected read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else if (cap_en) begin
      pipe_q <= arr_word;
    end
  end

  // Chip-enable state seen by the drivers: one or two stages depending on mode.
  always_comb begin
    if (mode == OUT_PIPE) begin
      live  = s2_sel && s2_rd;
      rdata = pipe_q;
    end else begin
      live  = s1_sel && s1_rd;
      rdata = arr_word;
    end
  end

  // Lane selects are always taken from the first stage.
  for (genvar l = 0; l < N_LANES; l++) begin : g_drv
    assign drv_en[l] = lane_drive(live, s1_bsel_n[l], oe_n);
  end

endmodule

// File: rtl/bytelane_port.sv
module bytelane_port
  import bytelane_pkg::*;
#(
  parameter int N_LANES = 2,
  parameter int LANE_W  = 9,
  parameter int ADDR_W  = 4,
  localparam int DW     = N_LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pipe_mode,
  input  logic               ce_lo_n,
  input  logic               ce_hi,
  input  logic               rd_wr,
  input  logic [N_LANES-1:0] bsel_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic               oe_n,
  output logic [N_LANES-1:0] wr_stb,
  output logic [DW-1:0]      rdata,
  output logic [N_LANES-1:0] drv_en
);

  logic               s1_sel;
  logic               s1_rd;
  logic [N_LANES-1:0] s1_bsel_n;
  logic [ADDR_W-1:0]  s1_addr;
  logic [DW-1:0]      s1_wdata;
  logic               s2_sel;
  logic               s2_rd;
  logic [DW-1:0]      arr_word;
  logic               cap_en;

  bytelane_inreg #(
    .N_LANES(N_LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
  ) u_inreg (
    .clk(clk), .rst_n(rst_n),
    .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rd_wr(rd_wr),
    .bsel_n(bsel_n), .addr(addr), .wdata(wdata),
    .s1_sel(s1_sel), .s1_rd(s1_rd), .s1_bsel_n(s1_bsel_n),
    .s1_addr(s1_addr), .s1_wdata(s1_wdata),
    .s2_sel(s2_sel), .s2_rd(s2_rd)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_wstb
    assign wr_stb[l] = lane_write(s1_sel, s1_rd, s1_bsel_n[l]);
  end

  bytelane_array #(
    .N_LANES(N_LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(s1_addr), .wr_word(s1_wdata),
    .rd_addr(s1_addr), .rd_word(arr_word)
  );

  bytelane_outpath #(
    .N_LANES(N_LANES), .LANE_W(LANE_W)
  ) u_outpath (
    .clk(clk), .rst_n(rst_n),
    .pipe_mode(pipe_mode), .oe_n(oe_n),
    .s1_sel(s1_sel), .s1_rd(s1_rd),
    .s2_sel(s2_sel), .s2_rd(s2_rd),
    .s1_bsel_n(s1_bsel_n), .arr_word(arr_word),
    .rdata(rdata), .drv_en(drv_en), .cap_en(cap_en)
  );

endmodule

module bytelane_port_chk #(
  parameter int N_LANES = 2,
  parameter int DW      = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pipe_mode,
  input logic               ce_lo_n,
  input logic               ce_hi,
  input logic               rd_wr,
  input logic [N_LANES-1:0] bsel_n,
  input logic               oe_n,
  input logic [N_LANES-1:0] wr_stb,
  input logic [DW-1:0]      rdata,
  input logic [N_LANES-1:0] drv_en,
  input logic               s1_sel,
  input logic               cap_en
);

  // R1: an unselected cycle never produces a write strobe.
  assert_no_strobe_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !((ce_lo_n == 1'b0) && (ce_hi == 1'b1)) |=> (wr_stb == '0));

  // R2: a selected write strobes exactly the lanes whose select was low.
  assert_strobe_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce_lo_n == 1'b0) && (ce_hi == 1'b1) && !rd_wr) |=> (wr_stb == ~$past(bsel_n)));

  // R3: in flow-through mode a write cycle never drives the outputs.
  assert_flow_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && (wr_stb != '0)) |-> (drv_en == '0));

  // R5: pipelined drivers go quiet one cycle after the first stage shows a deselect.
  assert_pipe_deselect_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !s1_sel) |=> (drv_en == '0));

  // R5: flow-through drivers go quiet right after an unselected sample.
  assert_flow_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !((ce_lo_n == 1'b0) && (ce_hi == 1'b1))) |=> (drv_en == '0));

  // R7: a high output enable keeps all drivers off.
  assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drv_en == '0));

  // R8: without a capture, the pipelined read word stays put.
  assert_pipe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !cap_en) |=> $stable(rdata));

endmodule

bind bytelane_port bytelane_port_chk #(.N_LANES(N_LANES), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rd_wr(rd_wr), .bsel_n(bsel_n),
  .oe_n(oe_n), .wr_stb(wr_stb), .rdata(rdata), .drv_en(drv_en),
  .s1_sel(s1_sel), .cap_en(cap_en)
);

// File: tb/test_bytelane_port.sv
module test_bytelane_port;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int AW = 4;
  localparam int DW = NL * LW;

  logic          clk;
  logic          rst_n;
  logic          pipe_mode;
  logic          ce_lo_n;
  logic          ce_hi;
  logic          rd_wr;
  logic [NL-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          oe_n;
  logic [NL-1:0] wr_stb;
  logic [DW-1:0] rdata;
  logic [NL-1:0] drv_en;

  bytelane_port #(.N_LANES(NL), .LANE_W(LW), .ADDR_W(AW)) i_bytelane_port (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rd_wr(rd_wr), .bsel_n(bsel_n),
    .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .wr_stb(wr_stb), .rdata(rdata), .drv_en(drv_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [NL-1:0] drv;
    logic [NL-1:0] wstb;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  sbq[$];
  string tagq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Cycle model of the port.
  logic [DW-1:0] m_mem [1<<AW];
  logic          m_s1, m_r1, m_s2, m_r2, m_pipe, m_oe;
  logic [NL-1:0] m_b1;
  logic [AW-1:0] m_a1;
  logic [DW-1:0] m_d1, m_pq;

  task automatic model_reset();
    for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
    m_s1 = 0; m_r1 = 0; m_s2 = 0; m_r2 = 0;
    m_b1 = '1; m_a1 = '0; m_d1 = '0; m_pq = '0;
  endtask

  task automatic model_edge(input logic en, input logic rd, input logic [NL-1:0] bs,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (m_s1 && !m_r1) begin
      if (!m_b1[1]) m_mem[m_a1][17:9] = m_d1[17:9];
      if (!m_b1[0]) m_mem[m_a1][8:0]  = m_d1[8:0];
    end
    if (m_s1 && m_r1) m_pq = m_mem[m_a1];
    m_s2 = m_s1; m_r2 = m_r1;
    m_s1 = en; m_r1 = rd; m_b1 = bs; m_a1 = a; m_d1 = d;
  endtask

  function automatic exp_t predict();
    exp_t e;
    logic live;
    live = m_pipe ? (m_s2 & m_r2) : (m_s1 & m_r1);
    for (int l = 0; l < NL; l++) begin
      e.drv[l]  = live & ~m_b1[l] & ~m_oe;
      e.wstb[l] = m_s1 & ~m_r1 & ~m_b1[l];
    end
    e.data = m_pipe ? m_pq : m_mem[m_a1];
    return e;
  endfunction

  // Driver: called just after a rising edge; drives, waits for the edge, predicts.
  task automatic step(input logic lo_n, input logic hi, input logic rd, input logic [NL-1:0] bs,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe,
                      input string tag);
    ce_lo_n = lo_n; ce_hi = hi; rd_wr = rd; bsel_n = bs; addr = a; wdata = d;
    @(posedge clk); #1;
    model_edge((lo_n === 1'b0) && (hi === 1'b1), rd, bs, a, d);
    oe_n = oe; m_oe = oe;
    sbq.push_back(predict());
    tagq.push_back(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] bs,
                    input string tag);
    step(1'b0, 1'b1, 1'b0, bs, a, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [NL-1:0] bs, input logic oe,
                    input string tag);
    step(1'b0, 1'b1, 1'b1, bs, a, '0, oe, tag);
  endtask

  task automatic idle(input logic [NL-1:0] bs, input string tag);
    step(1'b1, 1'b0, 1'b1, bs, '0, '0, 1'b0, tag);
  endtask

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset(input logic pm);
    drain();
    rst_n = 1'b0; pipe_mode = pm; m_pipe = pm;
    ce_lo_n = 1'b1; ce_hi = 1'b0; rd_wr = 1'b1; bsel_n = '1; addr = '0; wdata = '0;
    oe_n = 1'b0; m_oe = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (drv_en !== '0 || wr_stb !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: drv_en=%b wr_stb=%b expected 00 00", drv_en, wr_stb);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  // Monitor: compares one expected item per cycle away from the edge.
  exp_t  mon_e;
  string mon_t;
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      mon_e = sbq.pop_front();
      mon_t = tagq.pop_front();
      n_cmp++;
      if (drv_en !== mon_e.drv || wr_stb !== mon_e.wstb || rdata !== mon_e.data) begin
        n_bad++;
        $display("FAIL %s: actual drv=%b wstb=%b data=%h expected drv=%b wstb=%b data=%h",
                 mon_t, drv_en, wr_stb, rdata, mon_e.drv, mon_e.wstb, mon_e.data);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // Flow-through mode
    do_reset(1'b0);
    wr(4'd1, 18'h1A5C3, 2'b00, "R2");
    wr(4'd1, 18'h3FFFF, 2'b01, "R2");     // upper lane only
    rd(4'd1, 2'b00, 1'b0, "R3");
    wr(4'd2, 18'h2B6D4, 2'b10, "R2");     // lower lane only
    rd(4'd2, 2'b10, 1'b0, "R6");
    rd(4'd2, 2'b01, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 2'b00, 4'd1, 18'h00001, 1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, 2'b00, 4'd1, 18'h00002, 1'b0, "R1");
    rd(4'd1, 2'b00, 1'b0, "R1");
    rd(4'd1, 2'b00, 1'b1, "R7");
    rd(4'd1, 2'b00, 1'b0, "R7");
    wr(4'd7, 18'h12345, 2'b00, "R10");
    rd(4'd7, 2'b00, 1'b0, "R10");
    step(1'b1, 1'b0, 1'b1, 2'b00, 4'd7, '0, 1'b0, "R5");
    idle(2'b11, "R5");

    // Pipelined mode
    do_reset(1'b1);
    rd(4'd1, 2'b00, 1'b0, "R9");
    idle(2'b00, "R9");
    wr(4'd3, 18'h0F0F0, 2'b00, "R2");
    wr(4'd4, 18'h30303, 2'b00, "R2");
    rd(4'd3, 2'b00, 1'b0, "R4");
    rd(4'd4, 2'b00, 1'b0, "R4");
    idle(2'b00, "R5");
    idle(2'b00, "R5");
    rd(4'd3, 2'b00, 1'b0, "R8");
    wr(4'd3, 18'h11111, 2'b00, "R8");
    idle(2'b00, "R8");
    idle(2'b00, "R8");
    rd(4'd3, 2'b01, 1'b0, "R6");
    rd(4'd4, 2'b10, 1'b0, "R6");
    idle(2'b11, "R6");
    rd(4'd4, 2'b00, 1'b1, "R7");
    idle(2'b00, "R7");
    wr(4'd5, 18'h2AAAA, 2'b00, "R10");
    rd(4'd5, 2'b00, 1'b0, "R10");
    idle(2'b00, "R10");
    idle(2'b00, "R5");

    drain();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule